// File: doc/BRIEF.md
# Radix Page Table Walker

This block converts an effective address into a real address by descending a radix tree of translation tables held in memory. Each walk starts from three values: a root table base, the index width of the root table and the total number of address bits the tree translates. At every level the walker selects one 8-byte entry using a slice of the effective address. It reads that entry through a single-outstanding memory read port and either descends into the next table or stops on a leaf. On a leaf it returns the real address and the page size. On a fault it returns a fault code instead.

Before the descent the walker can first look up a per-process descriptor in a process table indexed by a process number. The descriptor then supplies the root base, the root index width and the translated size. Checking access rights, updating reference or change bits, and translating the entry addresses themselves are left to surrounding logic.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `mem_req_o` and `done_o` are all low.
- R2: At a level with base B, index width N and remaining size S, the entry read is at B + (((EA >> (S−N)) & (2^N−1)) × 8). All entry reads are 8-byte aligned.
- R3: An index width below 5, at the root or at any deeper level, ends the walk with the bad-configuration code (1) and issues no read for that level.
- R4: An index width greater than the remaining size ends the walk with the bad-configuration code (1) and issues no read for that level.
- R5: An entry whose bit 63 (valid) is 0 ends the walk with the missing-entry code (2).
- R6: A valid entry whose bit 62 (leaf) is 0 is a directory entry. The next level uses index width = bits [4:0] and base = bits [55:8] followed by eight zero bits, and the remaining size shrinks by the width of the level just read.
- R7: A valid leaf ends the walk with code 0. With S the size left after that level and M = 2^S−1, `psize_o` = S and `ra_o` = (page | ... ) formed as (P & ~M) | (EA & M), where P is bits [55:8] of the leaf followed by eight zero bits.
- R8: With the process-table option, the descriptor offset is PID × 16 from a table base that is 4 KiB aligned. If the offset is at or beyond 2^(size field + 12), the walk ends with code 2 and no read is made.
- R9: A fetched descriptor gives the translated size in bits [61:56], the root base in bits [55:8] (followed by eight zero bits) and the root index width in bits [4:0].
- R10: A walk reads at most 8 tree entries. A directory entry in the 8th read ends the walk with code 1, while a leaf in the 8th read still completes normally.
- R11: A memory request holds its address until granted, and no new request is raised while a granted read still awaits its response.
- R12: `done_o` is a one-cycle pulse. `fault_code_o`, `ra_o` and `psize_o` keep their values until the next walk ends, and `ra_o` and `psize_o` are 0 when the walk faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (accepted while idle) |
| ea_i | input | 64 | Effective address to translate |
| use_ptab_i | input | 1 | Fetch the root descriptor from the process table first |
| pid_i | input | PID_W | Process number indexing the process table |
| ptab_base_i | input | RA_W-12 | Process table base in 4 KiB units |
| ptab_size_i | input | 5 | Process table size field (bytes = 2^(field+12)) |
| root_base_i | input | RA_W-8 | Root table base in 256-byte units (direct mode) |
| root_nls_i | input | 5 | Root index width (direct mode) |
| root_size_i | input | 6 | Total translated size in bits (direct mode) |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | RA_W | Read byte address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | Walk finished (one cycle) |
| fault_code_o | output | 2 | 0 ok, 1 bad configuration, 2 missing entry |
| ra_o | output | RA_W | Translated real address |
| psize_o | output | 6 | Page size as a bit count |

## Verification
The hardest condition to reach is the depth limit. It needs a chain of eight valid directory entries whose index widths still fit inside the translated size. The stimulus builds that chain in the memory model with the minimum width of 5 and a 63-bit translated size, then runs it twice: once ending in a directory and once ending in a leaf. Faults partway down the tree are reached by building real upper levels and corrupting only the last entry. The bench counts memory reads per walk to confirm where each walk stopped.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;

    localparam int EA_W       = 64;
    localparam int NLS_W      = 5;
    localparam int SZ_W       = 6;
    localparam int MIN_NLS    = 5;
    localparam int VALID_BIT  = 63;
    localparam int LEAF_BIT   = 62;
    localparam int SZ_HI      = 61;
    localparam int SZ_LO      = 56;
    localparam int FRAME_LO   = 8;
    localparam int ENT_SHIFT  = 3;
    localparam int PTE_SHIFT  = 4;
    localparam int PTAB_ALIGN = 12;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_BADCFG = 2'd1,
        FLT_NOENT  = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_REQ   = 2'd2,
        ST_WAIT  = 2'd3
    } state_e;

endpackage

// File: rtl/rwalk_index.sv
module rwalk_index
    import rwalk_pkg::*;
#(
    parameter int RA_W = 56
) (
    input  logic [RA_W-FRAME_LO-1:0] base_i,
    input  logic [NLS_W-1:0]         nls_i,
    input  logic [SZ_W-1:0]          size_i,
    input  logic [EA_W-1:0]          ea_i,
    output logic [RA_W-1:0]          addr_o,
    output logic                     bad_o
);

    logic [SZ_W-1:0] shift;
    logic [EA_W-1:0] sel_mask;
    logic [EA_W-1:0] idx;
    logic [EA_W-1:0] byte_off;
    logic            unused_hi;

    always_comb begin
        bad_o    = (nls_i < NLS_W'(MIN_NLS)) || (SZ_W'(nls_i) > size_i);
        shift    = size_i - SZ_W'(nls_i);
        sel_mask = (EA_W'(1) << nls_i) - EA_W'(1);
        idx      = (ea_i >> shift) & sel_mask;
        byte_off = idx << ENT_SHIFT;
        addr_o   = {base_i, {FRAME_LO{1'b0}}} + byte_off[RA_W-1:0];
    end

    assign unused_hi = ^byte_off[EA_W-1:RA_W];

endmodule

// File: rtl/rwalk_merge.sv
module rwalk_merge
    import rwalk_pkg::*;
#(
    parameter int RA_W = 56
) (
    input  logic [RA_W-FRAME_LO-1:0] frame_i,
    input  logic [RA_W-1:0]          ea_lo_i,
    input  logic [SZ_W-1:0]          size_i,
    output logic [RA_W-1:0]          ra_o
);

    logic [RA_W-1:0] off_mask;

    always_comb begin
        off_mask = (RA_W'(1) << size_i) - RA_W'(1);
        ra_o     = ({frame_i, {FRAME_LO{1'b0}}} & ~off_mask) | (ea_lo_i & off_mask);
    end

endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import rwalk_pkg::*;
#(
    parameter int RA_W    = 56,
    parameter int PID_W   = 16,
    parameter int MAX_LVL = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [63:0]                 ea_i,
    input  logic                        use_ptab_i,
    input  logic [PID_W-1:0]            pid_i,
    input  logic [RA_W-13:0]            ptab_base_i,
    input  logic [4:0]                  ptab_size_i,
    input  logic [RA_W-9:0]             root_base_i,
    input  logic [4:0]                  root_nls_i,
    input  logic [5:0]                  root_size_i,
    output logic                        mem_req_o,
    output logic [RA_W-1:0]             mem_addr_o,
    input  logic                        mem_gnt_i,
    input  logic                        mem_rvalid_i,
    input  logic [63:0]                 mem_rdata_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [1:0]                  fault_code_o,
    output logic [RA_W-1:0]             ra_o,
    output logic [5:0]                  psize_o
);

    localparam int FR_W  = RA_W - FRAME_LO;
    localparam int LVL_W = $clog2(MAX_LVL + 1);
    localparam int OFF_W = PID_W + PTE_SHIFT;

    typedef struct packed {
        state_e            st;
        logic              pt;
        logic [FR_W-1:0]   base;
        logic [NLS_W-1:0]  nls;
        logic [SZ_W-1:0]   size;
        logic [LVL_W-1:0]  lvl;
        logic [EA_W-1:0]   ea;
        logic [RA_W-1:0]   addr;
        logic [RA_W-1:0]   ra;
        logic [SZ_W-1:0]   psize;
        fault_e            flt;
        logic              done;
    } regs_t;

    regs_t q, d;

    logic [RA_W-1:0]  idx_addr;
    logic             idx_bad;
    logic [SZ_W-1:0]  size_left;
    logic [RA_W-1:0]  leaf_ra;
    logic [OFF_W-1:0] pt_off;
    logic [EA_W-1:0]  pt_off_w;
    logic [6:0]       pt_lim;
    logic             pt_big;
    logic [RA_W-1:0]  pt_addr;
    logic [LVL_W-1:0] lvl_nx;
    logic             unused_bits;

    rwalk_index #(.RA_W(RA_W)) u_index (
        .base_i (q.base),
        .nls_i  (q.nls),
        .size_i (q.size),
        .ea_i   (q.ea),
        .addr_o (idx_addr),
        .bad_o  (idx_bad)
    );

    assign size_left = q.size - SZ_W'(q.nls);

    rwalk_merge #(.RA_W(RA_W)) u_merge (
        .frame_i (mem_rdata_i[RA_W-1:FRAME_LO]),
        .ea_lo_i (q.ea[RA_W-1:0]),
        .size_i  (size_left),
        .ra_o    (leaf_ra)
    );

    always_comb begin
        pt_off   = {pid_i, {PTE_SHIFT{1'b0}}};
        pt_off_w = EA_W'(pt_off);
        pt_lim   = 7'(ptab_size_i) + 7'(PTAB_ALIGN);
        pt_big   = (pt_off_w >> pt_lim) != '0;
        pt_addr  = {ptab_base_i, {PTAB_ALIGN{1'b0}}} + RA_W'(pt_off);
        lvl_nx   = q.lvl + LVL_W'(1);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.ea  = ea_i;
                    d.lvl = '0;
                    if (use_ptab_i) begin
                        if (pt_big) begin
                            d.flt   = FLT_NOENT;
                            d.ra    = '0;
                            d.psize = '0;
                            d.done  = 1'b1;
                        end else begin
                            d.addr = pt_addr;
                            d.pt   = 1'b1;
                            d.st   = ST_REQ;
                        end
                    end else begin
                        d.base = root_base_i;
                        d.nls  = root_nls_i;
                        d.size = root_size_i;
                        d.pt   = 1'b0;
                        d.st   = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (idx_bad) begin
                    d.flt   = FLT_BADCFG;
                    d.ra    = '0;
                    d.psize = '0;
                    d.done  = 1'b1;
                    d.st    = ST_IDLE;
                end else begin
                    d.addr = idx_addr;
                    d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (mem_gnt_i) d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    if (q.pt) begin
                        d.pt   = 1'b0;
                        d.size = mem_rdata_i[SZ_HI:SZ_LO];
                        d.base = mem_rdata_i[RA_W-1:FRAME_LO];
                        d.nls  = mem_rdata_i[NLS_W-1:0];
                        d.st   = ST_SETUP;
                    end else begin
                        d.lvl = lvl_nx;
                        if (!mem_rdata_i[VALID_BIT]) begin
                            d.flt   = FLT_NOENT;
                            d.ra    = '0;
                            d.psize = '0;
                            d.done  = 1'b1;
                            d.st    = ST_IDLE;
                        end else if (mem_rdata_i[LEAF_BIT]) begin
                            d.flt   = FLT_NONE;
                            d.ra    = leaf_ra;
                            d.psize = size_left;
                            d.done  = 1'b1;
                            d.st    = ST_IDLE;
                        end else if (lvl_nx == LVL_W'(MAX_LVL)) begin
                            d.flt   = FLT_BADCFG;
                            d.ra    = '0;
                            d.psize = '0;
                            d.done  = 1'b1;
                            d.st    = ST_IDLE;
                        end else begin
                            d.size = size_left;
                            d.base = mem_rdata_i[RA_W-1:FRAME_LO];
                            d.nls  = mem_rdata_i[NLS_W-1:0];
                            d.st   = ST_SETUP;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign unused_bits  = ^{mem_rdata_i[FRAME_LO-1:NLS_W], mem_rdata_i[LEAF_BIT-1:RA_W]};

    assign mem_req_o    = (q.st == ST_REQ);
    assign mem_addr_o   = q.addr;
    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = q.done;
    assign fault_code_o = q.flt;
    assign ra_o         = q.ra;
    assign psize_o      = q.psize;

endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
    parameter int RA_W    = 56,
    parameter int PID_W   = 16,
    parameter int MAX_LVL = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [RA_W-1:0] ea_lo_i,
    input logic            busy_o,
    input logic            mem_req_o,
    input logic [RA_W-1:0] mem_addr_o,
    input logic            mem_gnt_i,
    input logic            mem_rvalid_i,
    input logic            done_o,
    input logic [1:0]      fault_code_o,
    input logic [RA_W-1:0] ra_o,
    input logic [5:0]      psize_o
);

    logic            pend_q;
    logic [RA_W-1:0] ea_q;
    logic [RA_W-1:0] low_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ea_q   <= '0;
        end else begin
            if (mem_req_o && mem_gnt_i) pend_q <= 1'b1;
            else if (mem_rvalid_i)      pend_q <= 1'b0;
            if (start_i && !busy_o)     ea_q   <= ea_lo_i;
        end
    end

    assign low_mask = (RA_W'(1) << psize_o) - RA_W'(1);

    a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);

    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[2:0] == 3'b000));

    a_r11_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

    a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> !mem_req_o);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r12_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fault_code_o != 2'd3));

    a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_code_o == 2'd0) |-> (((ra_o ^ ea_q) & low_mask) == '0));

    a_r12_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_code_o != 2'd0) |-> (ra_o == '0 && psize_o == '0));

endmodule

bind radix_walker radix_walker_chk #(
    .RA_W(RA_W), .PID_W(PID_W), .MAX_LVL(MAX_LVL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .ea_lo_i      (ea_i[RA_W-1:0]),
    .busy_o       (busy_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .done_o       (done_o),
    .fault_code_o (fault_code_o),
    .ra_o         (ra_o),
    .psize_o      (psize_o)
);

// File: tb/tb_radix_walker.sv
module tb_radix_walker;

    localparam int RA_W  = 56;
    localparam int PID_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [63:0]      ea_i = '0;
    logic             use_ptab_i = 1'b0;
    logic [PID_W-1:0] pid_i = '0;
    logic [RA_W-13:0] ptab_base_i = '0;
    logic [4:0]       ptab_size_i = '0;
    logic [RA_W-9:0]  root_base_i = '0;
    logic [4:0]       root_nls_i = '0;
    logic [5:0]       root_size_i = '0;
    logic             mem_req_o;
    logic [RA_W-1:0]  mem_addr_o;
    logic             mem_gnt_i = 1'b0;
    logic             mem_rvalid_i = 1'b0;
    logic [63:0]      mem_rdata_i = '0;
    logic             busy_o;
    logic             done_o;
    logic [1:0]       fault_code_o;
    logic [RA_W-1:0]  ra_o;
    logic [5:0]       psize_o;

    always #5 clk = ~clk;

    radix_walker #(.RA_W(RA_W), .PID_W(PID_W), .MAX_LVL(8)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ea_i(ea_i),
        .use_ptab_i(use_ptab_i), .pid_i(pid_i), .ptab_base_i(ptab_base_i),
        .ptab_size_i(ptab_size_i), .root_base_i(root_base_i),
        .root_nls_i(root_nls_i), .root_size_i(root_size_i),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .fault_code_o(fault_code_o),
        .ra_o(ra_o), .psize_o(psize_o)
    );

    typedef struct {
        logic [RA_W-1:0] ra;
        int              ps;
        int              code;
        int              rd;
        string           tag;
    } exp_t;

    logic [63:0]     mem [longint];
    exp_t            exp_q [$];
    int              checks = 0;
    int              fails = 0;
    int              reads = 0;
    longint          next_free = 64'h100000;
    logic [RA_W-1:0] last_ra;

    task automatic check(input string tag, input string what, input longint got, input longint exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [63:0] rd_mem(input longint a);
        if (mem.exists(a)) return mem[a];
        return 64'd0;
    endfunction

    function automatic longint slot(input logic [63:0] ea, input longint base, input int nls, input int size);
        logic [63:0] idx;
        idx = (ea >> (size - nls)) & ((64'd1 << nls) - 64'd1);
        return base + longint'(idx) * 8;
    endfunction

    function automatic logic [63:0] mk_dir(input longint nb, input int nls);
        logic [63:0] b;
        b = 64'(nb);
        return {2'b10, 6'd0, b[55:8], 3'd0, 5'(nls)};
    endfunction

    function automatic logic [63:0] mk_leaf(input longint pn);
        logic [63:0] b;
        b = 64'(pn);
        return {2'b11, 6'd0, b[55:8], 8'd0};
    endfunction

    function automatic logic [63:0] mk_desc(input longint rb, input int nls, input int size);
        logic [63:0] b;
        b = 64'(rb);
        return {2'b00, 6'(size), b[55:8], 3'd0, 5'(nls)};
    endfunction

    // Reference walk written from the requirements (R2..R10)
    task automatic model(input logic [63:0] ea, input bit use_pt, input int pid, input longint ptb,
                         input int ptsz, input longint rb, input int rn, input int rs, output exp_t e);
        longint      base;
        int          nls;
        int          size;
        logic [63:0] ent;
        logic [63:0] m;
        e.ra = '0; e.ps = 0; e.code = 0; e.rd = 0;
        base = rb; nls = rn; size = rs;
        if (use_pt) begin
            if (longint'(pid) * 16 >= (64'sd1 <<< (ptsz + 12))) begin
                e.code = 2;
                return;
            end
            ent = rd_mem(ptb + longint'(pid) * 16);
            e.rd++;
            size = int'(ent[61:56]);
            base = longint'({ent[55:8], 8'd0});
            nls  = int'(ent[4:0]);
        end
        for (int lvl = 1; lvl <= 8; lvl++) begin
            if (nls < 5 || nls > size) begin
                e.code = 1;
                return;
            end
            ent = rd_mem(slot(ea, base, nls, size));
            e.rd++;
            if (!ent[63]) begin
                e.code = 2;
                return;
            end
            size = size - nls;
            if (ent[62]) begin
                m    = (64'd1 << size) - 64'd1;
                e.ra = RA_W'(({8'd0, ent[55:8], 8'd0} & ~m) | (ea & m));
                e.ps = size;
                return;
            end
            if (lvl == 8) begin
                e.code = 1;
                return;
            end
            nls  = int'(ent[4:0]);
            base = longint'({ent[55:8], 8'd0});
        end
    endtask

    // Build a chain of tables along the path of ea; kind: 0 leaf, 1 invalid, 2 none, 3 directory
    task automatic chain(input logic [63:0] ea, input longint base, input int nls, input int size,
                         input int nl [8], input int ndir, input int kind, input longint pn);
        longint b;
        int     n;
        int     s;
        b = base; n = nls; s = size;
        for (int i = 0; i < ndir; i++) begin
            mem[slot(ea, b, n, s)] = mk_dir(next_free, nl[i]);
            s = s - n;
            b = next_free;
            n = nl[i];
            next_free += 64'h100000;
        end
        if (n >= 5 && n <= s) begin
            if (kind == 0) mem[slot(ea, b, n, s)] = mk_leaf(pn);
            if (kind == 3) mem[slot(ea, b, n, s)] = mk_dir(next_free, 5);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] ea, input bit use_pt, input int pid,
                       input longint ptb, input int ptsz, input longint rb, input int rn, input int rs);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        model(ea, use_pt, pid, ptb, ptsz, rb, rn, rs, e);
        e.tag = tag;
        exp_q.push_back(e);
        ea_i        = ea;
        use_ptab_i  = use_pt;
        pid_i       = PID_W'(pid);
        ptab_base_i = (RA_W-12)'(ptb >> 12);
        ptab_size_i = 5'(ptsz);
        root_base_i = (RA_W-8)'(rb >> 8);
        root_nls_i  = 5'(rn);
        root_size_i = 6'(rs);
        reads       = 0;
        start_i     = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // Memory responder: variable grant delay and response latency
    initial begin
        int     gdly = 0;
        int     lat = 0;
        int     rr = 0;
        bit     pend = 0;
        longint paddr = 0;
        forever begin
            @(negedge clk);
            mem_gnt_i    = 1'b0;
            mem_rvalid_i = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    mem_rvalid_i = 1'b1;
                    mem_rdata_i  = rd_mem(paddr);
                    pend = 0;
                end else lat--;
            end else if (mem_req_o) begin
                if (gdly == 0) begin
                    mem_gnt_i = 1'b1;
                    paddr = longint'(mem_addr_o);
                    pend  = 1;
                    reads++;
                    rr++;
                    lat  = rr % 3;
                    gdly = (rr * 7) % 4;
                end else gdly--;
            end
        end
    end

    // Monitor: compare each completed walk with the scoreboard
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check("R12", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.tag, "fault code", longint'(fault_code_o), longint'(e.code));
                    check(e.tag, "real address", longint'(ra_o), longint'(e.ra));
                    check(e.tag, "page size", longint'(psize_o), longint'(e.ps));
                    check(e.tag, "read count", longint'(reads), longint'(e.rd));
                    last_ra = ra_o;
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam longint ROOT = 64'h10000;
    localparam longint PTB  = 64'h50000;
    localparam logic [63:0] EA_A = 64'h0000_0ABC_DEF1_2345;
    localparam logic [63:0] EA_B = 64'h0000_0FFF_FFFF_FFFF;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", longint'(busy_o), 0);
        check("R1", "req", longint'(mem_req_o), 0);
        check("R1", "done", longint'(done_o), 0);
        rst_n = 1'b1;

        // R2 R6 R7: four-level walk to a small page
        mem.delete();
        chain(EA_A, ROOT, 13, 52, '{9, 9, 9, 0, 0, 0, 0, 0}, 3, 0, 64'h00AB_CDEF_0000);
        run("R6", EA_A, 0, 0, 0, 0, ROOT, 13, 52);
        repeat (4) @(negedge clk);
        check("R12", "result held", longint'(ra_o), longint'(last_ra));

        // R7: two-level walk, leaf with large page and all-ones offset
        mem.delete();
        chain(EA_B, ROOT, 13, 52, '{9, 0, 0, 0, 0, 0, 0, 0}, 1, 0, 64'h0012_3456_7800);
        run("R7", EA_B, 0, 0, 0, 0, ROOT, 13, 52);

        // R5: invalid entry at second level
        mem.delete();
        chain(EA_A, ROOT, 13, 52, '{9, 0, 0, 0, 0, 0, 0, 0}, 1, 1, 0);
        run("R5", EA_A, 0, 0, 0, 0, ROOT, 13, 52);
        // R5: empty root table
        mem.delete();
        run("R5", EA_B, 0, 0, 0, 0, ROOT, 13, 52);

        // R3: root width below minimum, then a deeper width below minimum
        run("R3", EA_A, 0, 0, 0, 0, ROOT, 4, 52);
        mem.delete();
        chain(EA_A, ROOT, 13, 52, '{3, 0, 0, 0, 0, 0, 0, 0}, 1, 2, 0);
        run("R3", EA_A, 0, 0, 0, 0, ROOT, 13, 52);

        // R4: width larger than remaining size
        run("R4", EA_A, 0, 0, 0, 0, ROOT, 13, 10);

        // R8 R9: process table lookup then walk
        mem.delete();
        mem[PTB + 5 * 16] = mk_desc(ROOT, 13, 52);
        chain(EA_A, ROOT, 13, 52, '{9, 9, 9, 0, 0, 0, 0, 0}, 3, 0, 64'h0077_0000_1000);
        run("R9", EA_A, 1, 5, PTB, 0, 0, 0, 0);
        // R8: last slot of a 4 KiB table still fetched
        mem[PTB + 255 * 16] = mk_desc(ROOT, 13, 52);
        run("R8", EA_A, 1, 255, PTB, 0, 0, 0, 0);
        // R8: first slot beyond the table
        run("R8", EA_A, 1, 256, PTB, 0, 0, 0, 0);
        // R8: same process number inside a larger table
        mem[PTB + 256 * 16] = mk_desc(ROOT, 13, 52);
        run("R8", EA_A, 1, 256, PTB, 1, 0, 0, 0);

        // R10: eight directory reads abort, a leaf on the eighth completes
        mem.delete();
        chain(EA_B, ROOT, 5, 63, '{5, 5, 5, 5, 5, 5, 5, 0}, 7, 3, 0);
        run("R10", EA_B, 0, 0, 0, 0, ROOT, 5, 63);
        mem.delete();
        chain(EA_B, ROOT, 5, 63, '{5, 5, 5, 5, 5, 5, 5, 0}, 7, 0, 64'h00F0_0000_0000);
        run("R10", EA_B, 0, 0, 0, 0, ROOT, 5, 63);

        // R11 R2: back-to-back walks under varying grant and response timing
        mem.delete();
        chain(EA_B, ROOT, 13, 52, '{9, 9, 0, 0, 0, 0, 0, 0}, 2, 0, 64'h0033_4444_0000);
        for (int i = 0; i < 3; i++) run("R11", EA_B, 0, 0, 0, 0, ROOT, 13, 52);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule